// File: doc/BRIEF.md
# Qualified Ultra DMA Receive CRC Accumulator

This block keeps the running 16-bit CRC over the words that a device sends to the host during an Ultra DMA read burst. In its plain mode the CRC only takes in words that the receive FIFO actually accepted. In its qualified mode it takes in every device strobe for which one chosen control pin sits at a programmed level, whether or not the word was stored. This lets a host that ended a burst early drop the up to three trailing words the device may still send after the host withdraws its ready signal, while still keeping its CRC in step with the CRC the device computes.

Software sets the mode through one 8-bit qualifier register. A burst controller pulses `burst_start` at the start of each burst to load the seed. At the end of the burst it samples `crc_out` and compares it against the CRC sent by the device. That comparison, the FIFO itself and the strobe timing belong to neighbouring logic.

Top module: `udma_rx_crc`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h00, so qualified mode is off, and `crc_out` holds the seed 16'h4ABA.
- R2: A write with `cfg_we` high stores `cfg_wdata` and takes effect from the next clock. The register has three fields: bit 7 enables qualified mode, bit 3 is the required pin level, and bits 2..0 pick the control pin. `cfg_rdata` shows the stored value.
- R3: Bits 6..4 always read as zero, whatever value was written to them.
- R4: With bit 7 clear, the CRC advances only on a clock where `strobe` and `fifo_accept` are both high. The `ctl` pins have no effect in this mode, and a strobe without acceptance leaves the CRC unchanged.
- R5: With bit 7 set, the CRC advances on every `strobe` for which `ctl[sel]` equals bit 3, regardless of `fifo_accept`.
- R6: With bit 7 set, a strobe for which `ctl[sel]` differs from bit 3 leaves the CRC unchanged, even if the word is accepted.
- R7: With bit 7 set and a selector value of 6 or 7, no strobe ever advances the CRC.
- R8: One update folds the whole 16-bit word into the CRC, most significant bit first, using the polynomial x^16+x^12+x^5+1 (16'h1021). The result appears on `crc_out` one clock after the strobe.
- R9: `burst_start` loads 16'h4ABA into the CRC on the next clock and wins over an update in the same cycle.
- R10: `crc_out` holds its value on every clock in which no update and no `burst_start` occur.
- R11: When qualified mode is enabled with level 0 on the pin that carries the stop signal, trailing strobes while stop is low are included even though `fifo_accept` is low. Strobes after stop rises are not included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | One-cycle pulse that reloads the CRC seed |
| strobe | input | 1 | One-cycle pulse per device strobe edge, already synchronized |
| word_in | input | 16 | Data word that goes with the strobe |
| fifo_accept | input | 1 | The word of this strobe was written into the FIFO |
| ctl | input | 6 | Control pins the qualifier can select from |
| cfg_we | input | 1 | Qualifier register write enable |
| cfg_wdata | input | 8 | Qualifier register write data |
| cfg_rdata | output | 8 | Qualifier register readback |
| crc_out | output | 16 | Current registered CRC value |

## Verification
The hardest case to reach is the early-terminated burst. Here accepted words are followed by strobes whose words are dropped but must still count, and then by strobes that must not count once the stop pin rises. The bench builds this sequence directly. It enables qualified mode on the stop pin with level 0, then drives accepted words, then three strobes with `fifo_accept` low and stop still low, then a strobe with stop high. It follows the reference CRC word by word. Table vectors cover each mode against matching and mismatching pins, the out-of-range selectors, and a seed reload that collides with a strobe.

// File: rtl/udma_crc_pkg.sv
// Package: shared sizes, the CRC seed and polynomial, and the one-word CRC step.
// Assumes MSB-first processing of a full data word per call.
package udma_crc_pkg;

    localparam int DATA_W   = 16;
    localparam int CRC_W    = 16;
    localparam int CTL_N    = 6;
    localparam int SEL_W    = 3;
    localparam int CFG_W    = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_SEED = 16'h4ABA;

    // Field positions inside the qualifier register
    localparam int EN_BIT  = 7;
    localparam int LVL_BIT = 3;

    typedef struct packed {
        logic             en;
        logic             lvl;
        logic [SEL_W-1:0] sel;
    } qual_cfg_t;

    // Fold one data word into the CRC, most significant bit first
    function automatic logic [CRC_W-1:0] crc_word_step(
        input logic [CRC_W-1:0]  crc_in,
        input logic [DATA_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/qual_cfg_reg.sv
// Module: qualifier configuration register.
// Holds the enable, the level and the pin selector. Reserved bits are not stored
// and read back as zero. Assumes a single register, so the port has no address.
module qual_cfg_reg
    import udma_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output qual_cfg_t        cfg
);

    qual_cfg_t cfg_q;

    // Store the writable fields; everything clears on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.en  <= wdata[EN_BIT];
            cfg_q.lvl <= wdata[LVL_BIT];
            cfg_q.sel <= wdata[SEL_W-1:0];
        end
    end

    // Assemble the readback word, with the reserved bits forced to zero
    always_comb begin
        rdata                = '0;
        rdata[EN_BIT]        = cfg_q.en;
        rdata[LVL_BIT]       = cfg_q.lvl;
        rdata[SEL_W-1:0]     = cfg_q.sel;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/qual_gate.sv
// Module: update gate.
// Decides whether the current strobe updates the CRC. In plain mode the word must
// have been accepted. In qualified mode the selected control pin must equal the
// programmed level. Selector values with no pin never match.
module qual_gate
    import udma_crc_pkg::*;
(
    input  qual_cfg_t        cfg,
    input  logic             strobe,
    input  logic             fifo_accept,
    input  logic [CTL_N-1:0] ctl,
    output logic             upd
);

    localparam int SEL_N = 1 << SEL_W;

    logic [SEL_N-1:0] pin_match;

    // One match flag per selector value; values with no pin stay low
    genvar g;
    generate
        for (g = 0; g < SEL_N; g++) begin : g_sel
            if (g < CTL_N) begin : g_pin
                assign pin_match[g] = (ctl[g] == cfg.lvl);
            end else begin : g_none
                assign pin_match[g] = 1'b0;
            end
        end
    endgenerate

    // Pick the update condition for the active mode
    always_comb begin
        if (cfg.en) upd = strobe & pin_match[cfg.sel];
        else        upd = strobe & fifo_accept;
    end

endmodule

// File: rtl/crc_accum.sv
// Module: CRC accumulator register.
// Loads the seed on a burst start, otherwise folds in the word when enabled.
// Assumes at most one update per clock.
module crc_accum
    import udma_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_seed,
    input  logic              upd,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] crc_q;

    // Hold, reload or advance the CRC; the seed load wins over an update
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_q <= CRC_SEED;
        else if (load_seed) crc_q <= CRC_SEED;
        else if (upd)       crc_q <= crc_word_step(crc_q, data);
    end

    assign crc = crc_q;

endmodule

// File: rtl/udma_rx_crc.sv
// Module: top of the qualified receive CRC accumulator.
// Joins the configuration register, the update gate and the CRC register.
// Assumes strobe and burst_start are single-cycle pulses that are already synchronized.
module udma_rx_crc
    import udma_crc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        burst_start,
    input  logic                        strobe,
    input  logic [udma_crc_pkg::DATA_W-1:0] word_in,
    input  logic                        fifo_accept,
    input  logic [udma_crc_pkg::CTL_N-1:0]  ctl,
    input  logic                        cfg_we,
    input  logic [udma_crc_pkg::CFG_W-1:0]  cfg_wdata,
    output logic [udma_crc_pkg::CFG_W-1:0]  cfg_rdata,
    output logic [udma_crc_pkg::CRC_W-1:0]  crc_out
);

    qual_cfg_t cfg;
    logic      upd;

    // Configuration register
    qual_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    // Update qualification
    qual_gate u_gate (
        .cfg         (cfg),
        .strobe      (strobe),
        .fifo_accept (fifo_accept),
        .ctl         (ctl),
        .upd         (upd)
    );

    // CRC register
    crc_accum u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_seed (burst_start),
        .upd       (upd),
        .data      (word_in),
        .crc       (crc_out)
    );

endmodule

// File: rtl/udma_rx_crc_chk.sv
// Module: checker for udma_rx_crc, observing its ports only. Bound to the top below.
module udma_rx_crc_chk
    import udma_crc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              burst_start,
    input logic              strobe,
    input logic              fifo_accept,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic [CRC_W-1:0]  crc_out
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (cfg_rdata == '0 && crc_out == CRC_SEED));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[6:4] == 3'b000);

    // R9
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n) burst_start |=> crc_out == CRC_SEED);

    // R10
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !burst_start) |=> $stable(crc_out));

    // R4
    plain_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[EN_BIT] && !fifo_accept && !burst_start) |=> $stable(crc_out));

    // R7
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[EN_BIT] && cfg_rdata[2:0] > 3'd5 && !burst_start) |=> $stable(crc_out));

endmodule

bind udma_rx_crc udma_rx_crc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .strobe      (strobe),
    .fifo_accept (fifo_accept),
    .cfg_rdata   (cfg_rdata),
    .crc_out     (crc_out)
);

// File: tb/sim_udma_rx_crc.sv
// Bench for udma_rx_crc: a table of vectors, then directed reset and corner tests.
module sim_udma_rx_crc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_start = 1'b0;
    logic        strobe = 1'b0;
    logic [15:0] word_in = '0;
    logic        fifo_accept = 1'b0;
    logic [5:0]  ctl = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] crc_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    udma_rx_crc u0 (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .strobe(strobe),
        .word_in(word_in), .fifo_accept(fifo_accept), .ctl(ctl),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .crc_out(crc_out)
    );

    // Reference CRC: shift in one bit at a time, feedback taps at 12, 5 and 0
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r;
        logic        f;
        r = c;
        for (int k = 0; k < 16; k++) begin
            f = r[15] ^ d[15-k];
            r = r << 1;
            if (f) begin
                r[0]  = ~r[0];
                r[5]  = ~r[5];
                r[12] = ~r[12];
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs already set, advance past the edge and settle
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic start_burst();
        burst_start = 1'b1;
        tick();
        burst_start = 1'b0;
    endtask

    task automatic word(input logic [5:0] c, input logic acc, input logic [15:0] d);
        strobe = 1'b1; fifo_accept = acc; ctl = c; word_in = d;
        tick();
        strobe = 1'b0; fifo_accept = 1'b0;
    endtask

    // {expect_update, cfg, ctl, strobe, accept, data}
    localparam int NV = 11;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 8'h00, 6'h00, 1'b1, 1'b1, 16'h1234},  // R4 accepted word
        {1'b0, 8'h00, 6'h3F, 1'b1, 1'b0, 16'hBEEF},  // R4 strobe, not accepted
        {1'b0, 8'h00, 6'h00, 1'b0, 1'b1, 16'hCAFE},  // R4 accept with no strobe
        {1'b1, 8'h83, 6'h00, 1'b1, 1'b0, 16'h0F0F},  // R5 pin3 low, level 0
        {1'b0, 8'h83, 6'h08, 1'b1, 1'b1, 16'hA5A5},  // R6 pin3 high, level 0
        {1'b1, 8'h8D, 6'h20, 1'b1, 1'b0, 16'h8001},  // R5 pin5 high, level 1
        {1'b0, 8'h8D, 6'h1F, 1'b1, 1'b1, 16'h7777},  // R6 pin5 low, level 1
        {1'b0, 8'h86, 6'h00, 1'b1, 1'b1, 16'h1111},  // R7 selector 6
        {1'b0, 8'h8F, 6'h3F, 1'b1, 1'b1, 16'h2222},  // R7 selector 7
        {1'b1, 8'h08, 6'h00, 1'b1, 1'b1, 16'h5A5A},  // R4 disabled, ctl ignored
        {1'b1, 8'h80, 6'h3E, 1'b1, 1'b0, 16'hFFFF}   // R5 pin0 low, level 0
    };

    initial begin
        logic [15:0] exp;
        // R1 reset state
        repeat (3) tick();
        chk("R1 cfg", {8'h00, cfg_rdata}, 16'h0000);
        chk("R1 crc", crc_out, 16'h4ABA);
        rst_n = 1'b1;
        tick();

        // Table walk: configure, reseed, one word, compare
        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            v = VEC[i];
            write_cfg(v[31:24]);
            start_burst();
            chk("R9 seed", crc_out, 16'h4ABA);
            strobe = v[17]; fifo_accept = v[16]; ctl = v[23:18]; word_in = v[15:0];
            tick();
            strobe = 1'b0; fifo_accept = 1'b0;
            exp = v[32] ? ref_crc(16'h4ABA, v[15:0]) : 16'h4ABA;
            chk(v[32] ? "R8 update" : "R6/R7 no update", crc_out, exp);
        end

        // R2 / R3: field readback, reserved bits dropped
        write_cfg(8'hFF);
        chk("R3 rsvd", {8'h00, cfg_rdata}, 16'h008F);
        write_cfg(8'h75);
        chk("R2 fields", {8'h00, cfg_rdata}, 16'h0005);

        // R8: chained words, accepted in plain mode
        write_cfg(8'h00);
        start_burst();
        exp = 16'h4ABA;
        word(6'h00, 1'b1, 16'h0001); exp = ref_crc(exp, 16'h0001);
        word(6'h00, 1'b1, 16'hFFFF); exp = ref_crc(exp, 16'hFFFF);
        word(6'h00, 1'b1, 16'h8000); exp = ref_crc(exp, 16'h8000);
        chk("R8 chain", crc_out, exp);

        // R10: idle clocks hold the value
        repeat (4) tick();
        chk("R10 hold", crc_out, exp);

        // R9: seed load collides with a strobe
        burst_start = 1'b1; strobe = 1'b1; fifo_accept = 1'b1; word_in = 16'h1357;
        tick();
        burst_start = 1'b0; strobe = 1'b0; fifo_accept = 1'b0;
        chk("R9 priority", crc_out, 16'h4ABA);

        // R11: early termination, stop on pin 2, level 0
        write_cfg(8'h82);
        start_burst();
        exp = 16'h4ABA;
        word(6'h00, 1'b1, 16'h1001); exp = ref_crc(exp, 16'h1001);
        word(6'h00, 1'b1, 16'h2002); exp = ref_crc(exp, 16'h2002);
        word(6'h00, 1'b0, 16'h3003); exp = ref_crc(exp, 16'h3003);
        word(6'h00, 1'b0, 16'h4004); exp = ref_crc(exp, 16'h4004);
        word(6'h00, 1'b0, 16'h5005); exp = ref_crc(exp, 16'h5005);
        chk("R11 dribble", crc_out, exp);
        word(6'h04, 1'b0, 16'h6006);
        chk("R11 after stop", crc_out, exp);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule